// File: doc/BRIEF.md
# SMBus Register Target

This block is the serial front end of a small sensor register file. It watches the SCL and SDA lines of a two-wire bus using a much faster system clock, recognises start and stop conditions, and answers to one fixed 7-bit target address. After the address, the first byte of a write transfer loads a register pointer. Any further write bytes are stored through that pointer. A read transfer returns the register that the pointer selects.

The register map has three kinds of entry. Several writable registers are read at one address and written at another. Other registers use the same address for both directions. A third group is read-only: live sensor values arrive on input ports, and two identification bytes are fixed. A write that targets the trigger address stores no data and instead emits a one-cycle measurement trigger.

When bit 7 of the consecutive-alert register (0x22) is set, a transfer that stalls with no line activity for a set number of system clocks is abandoned, and the block returns to idle. The block never drives SDA high. It only requests a low level through an open-drain pull output.

Top module: `smb_reg_target`

## Requirements
- R1: Only the 7-bit address 0x4C (1001100b) is acknowledged. The address arrives MSB first, followed by the R/W bit (0 = write, 1 = read). For any other address there is no ACK and no register or pointer changes.
- R2: A start (SDA falls while SCL is high) begins address reception from any state. A stop (SDA rises while SCL is high) returns the block to idle with SDA released.
- R3: Every byte takes nine SCL clocks. The block pulls SDA low during the ninth clock for a matching address and for every byte written to it. The pull output changes only while SCL is low.
- R4: In a write transfer, the first byte after the address sets the pointer. Each later byte is written to the register at the pointer. The pointer does not advance.
- R5: A read transfer shifts out the byte at the pointer, MSB first. After a controller ACK the same register is sent again. After a controller NACK, SDA is released.
- R6: Configuration is read at 0x03 and written at 0x09. Conversion rate is read at 0x04 and written at 0x0A. The four limits are read at 0x05–0x08 and written at 0x0B–0x0E. A write to one of the read addresses changes nothing.
- R7: Registers 0x11–0x14 and 0x19–0x22 read back the value last written at the same address.
- R8: The reset values are:
  - 0x03 = 0x00
  - 0x04 = 0x08
  - 0x05 = 0x55
  - 0x06 = 0x00
  - 0x07 = 0x55
  - 0x08 = 0x00
  - 0x11–0x14 = 0x00
  - 0x19 = 0x55
  - 0x20 = 0x55
  - 0x21 = 0x0A
  - 0x22 = 0x01
- R9: The read-only registers are:
  - 0x00 returns `local_temp_i`
  - 0x01 returns `remote_hi_i`
  - 0x02 returns `status_i`
  - 0x10 returns `remote_lo_i`
  - 0xFE returns 0x41
  - 0xFF returns 0x57

  Writes to these addresses are acknowledged and have no effect.
- R10: Unmapped addresses read as 0x00. Writes to them are acknowledged and ignored.
- R11: Each data byte written to 0x0F produces exactly one single-cycle `oneshot_o` pulse, whatever its value. Nothing is stored, so 0x0F reads as 0x00. A transfer that only sets the pointer to 0x0F produces no pulse.
- R12: With bit 7 of 0x22 set, TIMEOUT_CYC system clocks with no change on SCL or SDA during a transfer force idle and release SDA. After reset the bit is clear and no timeout occurs.
- R13: `cfg_o` and `conv_rate_o` always show the current configuration and conversion-rate registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_pull_o | output | 1 | 1 = pull SDA low (open-drain enable) |
| local_temp_i | input | 8 | Local sensor reading, register 0x00 |
| remote_hi_i | input | 8 | Remote reading high byte, register 0x01 |
| status_i | input | 8 | Status byte, register 0x02 |
| remote_lo_i | input | 8 | Remote reading low byte, register 0x10 |
| oneshot_o | output | 1 | One-cycle measurement trigger |
| cfg_o | output | 8 | Configuration register value |
| conv_rate_o | output | 8 | Conversion-rate register value |

## Verification
The bench builds the block with the default target address, two synchronizer stages and TIMEOUT_CYC = 1000. It holds each SCL phase for ten system clocks. The short timeout lets a stall of 1500 cycles, placed in the middle of an address acknowledge, show both the disabled case (SDA stays pulled) and the enabled case (the block goes idle and ignores the rest of the byte). The ten-cycle phases leave the synchronizer and edge-detect latency visible while SDA still settles well before each SCL rise.

// File: rtl/smb_pkg.sv
package smb_pkg;
  typedef logic [7:0] byte_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } bus_st_e;

  // read/write register table, entry i at bits [8*i +: 8]
  localparam int NUM_RW   = 14;
  localparam int IDX_CFG  = 0;
  localparam int IDX_RATE = 1;
  localparam int IDX_CONS = 13;
  localparam int TMO_EN_BIT = 7;

  localparam logic [NUM_RW*8-1:0] RD_MAP = {
    8'h22, 8'h21, 8'h20, 8'h19, 8'h14, 8'h13, 8'h12,
    8'h11, 8'h08, 8'h07, 8'h06, 8'h05, 8'h04, 8'h03};
  localparam logic [NUM_RW*8-1:0] WR_MAP = {
    8'h22, 8'h21, 8'h20, 8'h19, 8'h14, 8'h13, 8'h12,
    8'h11, 8'h0E, 8'h0D, 8'h0C, 8'h0B, 8'h0A, 8'h09};
  localparam logic [NUM_RW*8-1:0] RST_MAP = {
    8'h01, 8'h0A, 8'h55, 8'h55, 8'h00, 8'h00, 8'h00,
    8'h00, 8'h00, 8'h55, 8'h00, 8'h55, 8'h08, 8'h00};

  localparam byte_t ADR_LOCAL   = 8'h00;
  localparam byte_t ADR_RHI     = 8'h01;
  localparam byte_t ADR_STAT    = 8'h02;
  localparam byte_t ADR_RLO     = 8'h10;
  localparam byte_t ADR_ONESHOT = 8'h0F;
  localparam byte_t ADR_MFG     = 8'hFE;
  localparam byte_t ADR_REV     = 8'hFF;
  localparam byte_t VAL_MFG     = 8'h41;
  localparam byte_t VAL_REV     = 8'h57;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      last_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], d_i};
      last_q <= sh_q[STAGES-1];
    end
  end

  assign q_o    = sh_q[STAGES-1];
  assign rise_o = q_o & ~last_q;
  assign fall_o = ~q_o & last_q;
endmodule

// File: rtl/smb_idle_timer.sv
module smb_idle_timer #(
  parameter int TIMEOUT_CYC = 1250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic busy_i,
  input  logic activity_i,
  output logic expire_o
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (!busy_i || activity_i) cnt_q <= '0;
    else if (cnt_q != LIMIT)      cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = en_i && busy_i && (cnt_q == LIMIT);
endmodule

// File: rtl/smb_bus_fsm.sv
module smb_bus_fsm
  import smb_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h4C
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  scl_rise_i,
  input  logic  scl_fall_i,
  input  logic  sda_i,
  input  logic  start_i,
  input  logic  stop_i,
  input  logic  tmo_i,
  input  byte_t rd_data_i,
  output logic  pull_o,
  output logic  wr_valid_o,
  output logic  wr_first_o,
  output byte_t wr_data_o,
  output logic  idle_o,
  output logic  rd_active_o
);
  bus_st_e    st_q;
  logic [3:0] cnt_q;
  byte_t      sh_q;
  logic [6:0] tx_q;
  logic       pull_q, rw_q, first_q, wr_valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      tx_q       <= '0;
      pull_q     <= 1'b0;
      rw_q       <= 1'b0;
      first_q    <= 1'b0;
      wr_valid_q <= 1'b0;
    end else begin
      wr_valid_q <= 1'b0;
      if (tmo_i) begin
        st_q   <= ST_IDLE;
        pull_q <= 1'b0;
      end else if (start_i) begin
        st_q   <= ST_ADDR;
        cnt_q  <= '0;
        pull_q <= 1'b0;
      end else if (stop_i) begin
        st_q   <= ST_IDLE;
        pull_q <= 1'b0;
      end else begin
        case (st_q)
          ST_ADDR: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[6:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              if (sh_q[7:1] == TARGET_ADDR) begin
                pull_q <= 1'b1;
                rw_q   <= sh_q[0];
                st_q   <= ST_ADDR_ACK;
              end else begin
                st_q <= ST_IDLE;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall_i) begin
              cnt_q <= '0;
              if (rw_q) begin
                tx_q   <= rd_data_i[6:0];
                pull_q <= ~rd_data_i[7];
                st_q   <= ST_RD;
              end else begin
                pull_q  <= 1'b0;
                first_q <= 1'b1;
                st_q    <= ST_WR;
              end
            end
          end
          ST_WR: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[6:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              pull_q     <= 1'b1;
              wr_valid_q <= 1'b1;
              st_q       <= ST_WR_ACK;
            end
          end
          ST_WR_ACK: begin
            if (scl_fall_i) begin
              pull_q  <= 1'b0;
              cnt_q   <= '0;
              first_q <= 1'b0;
              st_q    <= ST_WR;
            end
          end
          ST_RD: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i) begin
              if (cnt_q == 4'd8) begin
                pull_q <= 1'b0;
                st_q   <= ST_RD_ACK;
              end else begin
                pull_q <= ~tx_q[6];
                tx_q   <= {tx_q[5:0], 1'b0};
              end
            end
          end
          ST_RD_ACK: begin
            if (scl_rise_i) begin
              if (sda_i) st_q <= ST_IDLE;  // controller NACK
            end else if (scl_fall_i) begin
              tx_q   <= rd_data_i[6:0];
              pull_q <= ~rd_data_i[7];
              cnt_q  <= '0;
              st_q   <= ST_RD;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign pull_o      = pull_q;
  assign wr_valid_o  = wr_valid_q;
  assign wr_first_o  = first_q;
  assign wr_data_o   = sh_q;
  assign idle_o      = (st_q == ST_IDLE);
  assign rd_active_o = (st_q == ST_RD) || (st_q == ST_RD_ACK);
endmodule

// File: rtl/smb_regs.sv
module smb_regs
  import smb_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_valid_i,
  input  logic  wr_first_i,
  input  byte_t wr_data_i,
  input  byte_t local_temp_i,
  input  byte_t remote_hi_i,
  input  byte_t status_i,
  input  byte_t remote_lo_i,
  output byte_t rd_data_o,
  output byte_t ptr_o,
  output logic  oneshot_o,
  output logic  tmo_en_o,
  output byte_t cfg_o,
  output byte_t conv_rate_o
);
  byte_t                 ptr_q;
  logic [NUM_RW*8-1:0]   regs_q;
  logic [NUM_RW-1:0]     wr_hit, rd_hit;
  logic                  oneshot_q;
  logic                  data_wr;

  assign data_wr = wr_valid_i & ~wr_first_i;

  for (genvar i = 0; i < NUM_RW; i++) begin : g_map
    assign wr_hit[i] = data_wr && (ptr_q == WR_MAP[8*i +: 8]);
    assign rd_hit[i] = (ptr_q == RD_MAP[8*i +: 8]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q     <= '0;
      regs_q    <= RST_MAP;
      oneshot_q <= 1'b0;
    end else begin
      if (wr_valid_i && wr_first_i) ptr_q <= wr_data_i;
      for (int i = 0; i < NUM_RW; i++)
        if (wr_hit[i]) regs_q[8*i +: 8] <= wr_data_i;
      oneshot_q <= data_wr && (ptr_q == ADR_ONESHOT);
    end
  end

  always_comb begin
    rd_data_o = '0;
    case (ptr_q)
      ADR_LOCAL: rd_data_o = local_temp_i;
      ADR_RHI:   rd_data_o = remote_hi_i;
      ADR_STAT:  rd_data_o = status_i;
      ADR_RLO:   rd_data_o = remote_lo_i;
      ADR_MFG:   rd_data_o = VAL_MFG;
      ADR_REV:   rd_data_o = VAL_REV;
      default:   ;
    endcase
    for (int i = 0; i < NUM_RW; i++)
      if (rd_hit[i]) rd_data_o = regs_q[8*i +: 8];
  end

  assign ptr_o       = ptr_q;
  assign oneshot_o   = oneshot_q;
  assign tmo_en_o    = regs_q[8*IDX_CONS + TMO_EN_BIT];
  assign cfg_o       = regs_q[8*IDX_CFG +: 8];
  assign conv_rate_o = regs_q[8*IDX_RATE +: 8];
endmodule

// File: rtl/smb_reg_target.sv
module smb_reg_target
  import smb_pkg::*;
#(
  parameter logic [6:0] TARGET_ADDR = 7'h4C,
  parameter int TIMEOUT_CYC = 1250000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  input  logic [7:0] local_temp_i,
  input  logic [7:0] remote_hi_i,
  input  logic [7:0] status_i,
  input  logic [7:0] remote_lo_i,
  output logic       oneshot_o,
  output logic [7:0] cfg_o,
  output logic [7:0] conv_rate_o
);
  logic  scl_s, scl_rise, scl_fall;
  logic  sda_s, sda_rise, sda_fall;
  logic  start, stop, tmo, tmo_en;
  logic  eng_idle, rd_active, wr_valid, wr_first;
  byte_t wr_data, rd_data, ptr;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk_i, .rst_ni, .d_i(scl_i), .q_o(scl_s), .rise_o(scl_rise), .fall_o(scl_fall));

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk_i, .rst_ni, .d_i(sda_i), .q_o(sda_s), .rise_o(sda_rise), .fall_o(sda_fall));

  assign start = sda_fall & scl_s;
  assign stop  = sda_rise & scl_s;

  smb_idle_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk_i, .rst_ni,
    .en_i(tmo_en),
    .busy_i(~eng_idle),
    .activity_i(scl_rise | scl_fall | sda_rise | sda_fall),
    .expire_o(tmo));

  smb_bus_fsm #(.TARGET_ADDR(TARGET_ADDR)) u_fsm (
    .clk_i, .rst_ni,
    .scl_rise_i(scl_rise), .scl_fall_i(scl_fall), .sda_i(sda_s),
    .start_i(start), .stop_i(stop), .tmo_i(tmo),
    .rd_data_i(rd_data),
    .pull_o(sda_pull_o), .wr_valid_o(wr_valid), .wr_first_o(wr_first),
    .wr_data_o(wr_data), .idle_o(eng_idle), .rd_active_o(rd_active));

  smb_regs u_regs (
    .clk_i, .rst_ni,
    .wr_valid_i(wr_valid), .wr_first_i(wr_first), .wr_data_i(wr_data),
    .local_temp_i, .remote_hi_i, .status_i, .remote_lo_i,
    .rd_data_o(rd_data), .ptr_o(ptr), .oneshot_o, .tmo_en_o(tmo_en),
    .cfg_o, .conv_rate_o);
endmodule

module smb_reg_target_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_i,
  input logic       sda_pull_o,
  input logic       oneshot_o,
  input logic       tmo_i,
  input logic       idle_i,
  input logic       wr_valid_i,
  input logic       rd_active_i,
  input logic [7:0] ptr_i
);
  p_oneshot_width_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oneshot_o |=> !oneshot_o);

  p_oneshot_src_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oneshot_o |-> $past(wr_valid_i));

  p_idle_released_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |-> !sda_pull_o);

  p_tmo_to_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_i |=> idle_i);

  p_ptr_hold_read_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_active_i |=> $stable(ptr_i));

  p_pull_scl_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$stable(sda_pull_o) && !$past(tmo_i)) |-> !scl_i);
endmodule

bind smb_reg_target smb_reg_target_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
  .oneshot_o(oneshot_o), .tmo_i(tmo), .idle_i(eng_idle), .wr_valid_i(wr_valid),
  .rd_active_i(rd_active), .ptr_i(ptr));

// File: tb/tb_smb_reg_target.sv
module tb_smb_reg_target;
  localparam int Q   = 10;
  localparam int TMO = 1000;
  localparam logic [6:0] TADR = 7'h4C;

  typedef struct packed {
    logic       wr;
    logic [7:0] adr;
    logic [7:0] dat;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 43;
  localparam vec_t VECS [NV] = '{
    // R8 reset values
    '{1'b0, 8'h03, 8'h00, 4'd8}, '{1'b0, 8'h04, 8'h08, 4'd8}, '{1'b0, 8'h05, 8'h55, 4'd8},
    '{1'b0, 8'h06, 8'h00, 4'd8}, '{1'b0, 8'h07, 8'h55, 4'd8}, '{1'b0, 8'h08, 8'h00, 4'd8},
    '{1'b0, 8'h11, 8'h00, 4'd8}, '{1'b0, 8'h19, 8'h55, 4'd8}, '{1'b0, 8'h20, 8'h55, 4'd8},
    '{1'b0, 8'h21, 8'h0A, 4'd8}, '{1'b0, 8'h22, 8'h01, 4'd8},
    // R9 fixed and live read-only values
    '{1'b0, 8'hFE, 8'h41, 4'd9}, '{1'b0, 8'hFF, 8'h57, 4'd9}, '{1'b0, 8'h00, 8'h19, 4'd9},
    '{1'b0, 8'h01, 8'h2A, 4'd9}, '{1'b0, 8'h02, 8'h80, 4'd9}, '{1'b0, 8'h10, 8'h40, 4'd9},
    // R6 split addresses
    '{1'b1, 8'h09, 8'h5A, 4'd6}, '{1'b0, 8'h03, 8'h5A, 4'd6}, '{1'b1, 8'h0A, 8'h03, 4'd6},
    '{1'b0, 8'h04, 8'h03, 4'd6}, '{1'b1, 8'h0B, 8'h64, 4'd6}, '{1'b0, 8'h05, 8'h64, 4'd6},
    '{1'b1, 8'h0E, 8'hF6, 4'd6}, '{1'b0, 8'h08, 8'hF6, 4'd6}, '{1'b1, 8'h03, 8'hFF, 4'd6},
    '{1'b0, 8'h03, 8'h5A, 4'd6}, '{1'b1, 8'h05, 8'h11, 4'd6}, '{1'b0, 8'h05, 8'h64, 4'd6},
    // R7 shared addresses
    '{1'b1, 8'h13, 8'hC0, 4'd7}, '{1'b0, 8'h13, 8'hC0, 4'd7}, '{1'b1, 8'h20, 8'h7D, 4'd7},
    '{1'b0, 8'h20, 8'h7D, 4'd7}, '{1'b1, 8'h12, 8'h3C, 4'd7}, '{1'b0, 8'h12, 8'h3C, 4'd7},
    // R9 writes ignored
    '{1'b1, 8'hFE, 8'h00, 4'd9}, '{1'b0, 8'hFE, 8'h41, 4'd9}, '{1'b1, 8'h00, 8'hEE, 4'd9},
    '{1'b0, 8'h00, 8'h19, 4'd9},
    // R10 unmapped, R11 trigger address reads zero
    '{1'b0, 8'h30, 8'h00, 4'd10}, '{1'b1, 8'h30, 8'h77, 4'd10}, '{1'b0, 8'h30, 8'h00, 4'd10},
    '{1'b0, 8'h0F, 8'h00, 4'd11}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_bus;
  logic sda_pull_o, oneshot_o;
  logic [7:0] cfg_o, conv_rate_o;
  int n_chk = 0;
  int n_bad = 0;
  int os_cnt = 0;

  always #2 clk = ~clk;

  assign sda_bus = sda_m & ~sda_pull_o;

  smb_reg_target #(.TARGET_ADDR(TADR), .TIMEOUT_CYC(TMO), .SYNC_STAGES(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
    .sda_pull_o(sda_pull_o),
    .local_temp_i(8'h19), .remote_hi_i(8'h2A), .status_i(8'h80), .remote_lo_i(8'h40),
    .oneshot_o(oneshot_o), .cfg_o(cfg_o), .conv_rate_o(conv_rate_o));

  always @(posedge clk) if (rst_n && oneshot_o) os_cnt <= os_cnt + 1;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, output logic s);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(Q);
    s = sda_bus; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) send_bit(b[i], s);
    send_bit(1'b1, s);
    ack = ~s;
  endtask

  task automatic get_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      send_bit(1'b1, s);
      b[i] = s;
    end
    send_bit(~mack, s);
  endtask

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d, output logic ok);
    logic k1, k2, k3;
    bus_start;
    put_byte({TADR, 1'b0}, k1);
    put_byte(a, k2);
    put_byte(d, k3);
    bus_stop;
    ok = k1 & k2 & k3;
  endtask

  task automatic reg_read(input logic [7:0] a, output logic [7:0] d, output logic ok);
    logic k1, k2, k3;
    bus_start;
    put_byte({TADR, 1'b0}, k1);
    put_byte(a, k2);
    bus_start;
    put_byte({TADR, 1'b1}, k3);
    get_byte(1'b0, d);
    bus_stop;
    ok = k1 & k2 & k3;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic ok, a, s;
    logic [7:0] d, d2, d3;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    // reset state, R8 R13 R2
    check("R2 pull idle after reset", sda_pull_o, 0);
    check("R11 oneshot low after reset", oneshot_o, 0);
    check("R13 cfg_o reset", cfg_o, 8'h00);
    check("R13 conv_rate_o reset", conv_rate_o, 8'h08);

    foreach (VECS[i]) begin
      if (VECS[i].wr) begin
        reg_write(VECS[i].adr, VECS[i].dat, ok);
        check($sformatf("R%0d R3 write ack @%0h", VECS[i].req, VECS[i].adr), ok, 1);
      end else begin
        reg_read(VECS[i].adr, d, ok);
        check($sformatf("R%0d read @%0h", VECS[i].req, VECS[i].adr),
              {ok, d}, {1'b1, VECS[i].dat});
      end
    end
    check("R13 cfg_o follows write", cfg_o, 8'h5A);
    check("R13 conv_rate_o follows write", conv_rate_o, 8'h03);

    // R1 wrong address: no ack, nothing written
    bus_start;
    put_byte({7'h4D, 1'b0}, a);
    check("R1 no ack for 0x4D", a, 0);
    put_byte(8'h09, a);
    check("R1 no ack after mismatch", a, 0);
    put_byte(8'h00, a);
    bus_stop;
    reg_read(8'h03, d, ok);
    check("R1 cfg untouched by foreign write", {ok, d}, {1'b1, 8'h5A});

    // R5 read repeats on ACK, releases on NACK
    bus_start;
    put_byte({TADR, 1'b0}, a);
    put_byte(8'h05, a);
    bus_start;
    put_byte({TADR, 1'b1}, a);
    get_byte(1'b1, d);
    get_byte(1'b1, d2);
    get_byte(1'b0, d3);
    check("R5 released after NACK", sda_pull_o, 0);
    bus_stop;
    check("R5 three reads same register", {d, d2, d3}, {8'h64, 8'h64, 8'h64});

    // R4 pointer does not advance
    bus_start;
    put_byte({TADR, 1'b0}, a);
    put_byte(8'h0B, a);
    put_byte(8'h10, a);
    put_byte(8'h20, a);
    put_byte(8'h30, a);
    check("R4 last data byte ack", a, 1);
    bus_stop;
    reg_read(8'h05, d, ok);
    check("R4 last byte lands at pointer", {ok, d}, {1'b1, 8'h30});
    reg_read(8'h06, d, ok);
    check("R4 next register unchanged", {ok, d}, {1'b1, 8'h00});

    // R11 one-shot pulses
    os_cnt = 0;
    reg_write(8'h0F, 8'hA5, ok);
    check("R11 one pulse per data byte", os_cnt, 1);
    bus_start;
    put_byte({TADR, 1'b0}, a);
    put_byte(8'h0F, a);
    put_byte(8'h00, a);
    put_byte(8'hFF, a);
    put_byte(8'h3C, a);
    bus_stop;
    check("R11 three data bytes three pulses", os_cnt, 4);
    bus_start;
    put_byte({TADR, 1'b0}, a);
    put_byte(8'h0F, a);
    bus_stop;
    check("R11 pointer-only no pulse", os_cnt, 4);

    // R12 timeout disabled after reset: stall during address ack
    bus_start;
    for (int i = 6; i >= 0; i--) send_bit(TADR[i], s);
    send_bit(1'b0, s);
    check("R12 pulling in address ack", sda_pull_o, 1);
    tick(TMO + 500);
    check("R12 disabled timeout keeps ack", sda_pull_o, 1);
    send_bit(1'b1, s);
    check("R12 ack completes", s, 0);
    bus_stop;

    // enable timeout
    reg_write(8'h22, 8'h81, ok);
    reg_read(8'h22, d, ok);
    check("R12 enable bit written", {ok, d}, {1'b1, 8'h81});
    bus_start;
    for (int i = 6; i >= 0; i--) send_bit(TADR[i], s);
    send_bit(1'b0, s);
    check("R12 pulling before stall", sda_pull_o, 1);
    tick(TMO + 500);
    check("R12 released after timeout", sda_pull_o, 0);
    send_bit(1'b1, s);
    put_byte(8'h09, a);
    check("R12 idle ignores rest of transfer", a, 0);
    bus_stop;
    reg_read(8'h03, d, ok);
    check("R12 recovers after timeout", {ok, d}, {1'b1, 8'h5A});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule